// File: doc/BRIEF.md
# Masked breakpoint and watch comparator

This block sits beside a CPU bus and watches every bus cycle for addresses of interest. It holds a set of comparator slots. Each slot has a pre-masked match address, a mask, six mode enables and a trigger field. Software fills the slots through a single serial shift chain while comparison is switched off. It then switches comparison on and lets the CPU run.

On each valid bus cycle the block sorts the access into one of three types: instruction fetch, data read or data write. It tests every slot against the masked bus address and that type. A breakpoint hit raises a halt request that stays up until a step or a disable. A hit of any kind produces a one-cycle push of an event record. The record carries the instruction address, bus address, bus data, a 4-bit compressed mode code, the lowest hitting slot number and the 24-bit cycle count. An event FIFO that is not part of this block takes the record. The trigger field is stored but has no effect: every slot behaves as "always".

Top module: `bw_unit`

## Requirements
- R1: After reset, `halt_o` and `push_o` are low.
- R2: While `enable_i` is high, shift pulses are ignored and slot contents do not change.
- R3: While `enable_i` is low, each `shift_i` cycle moves `shift_bit_i` into a chain of NUM_SLOTS×42 bits, slot 0 first. Within each slot the bits arrive LSB first in this order: 16 address bits, 16 mask bits, 6 mode bits, 4 trigger bits.
- R4: A slot matches when (bus_addr_i AND mask) equals its stored address.
- R5: Bus cycle classification gives priority fetch > write > read. Mode bit 0 enables break on fetch, bit 1 break on read, bit 2 break on write, bit 3 watch on fetch, bit 4 watch on read and bit 5 watch on write. A slot whose mode is all zero never fires.
- R6: With `enable_i` low, no hit is reported, `push_o` stays low and `halt_o` is low one cycle later.
- R7: A breakpoint hit on a valid bus cycle sets `halt_o` at the next edge. `halt_o` then holds until a `step_i` cycle without a new breakpoint hit, or until `enable_i` falls.
- R8: Any hit pushes a record one cycle after the bus cycle. `push_mode_o` is {0, break-type bits} when a breakpoint hit, and otherwise {1, watch-type bits}. Bits 2..0 are one-hot in the order fetch (bit 0), read (bit 1), write (bit 2).
- R9: When several slots hit, `push_slot_o` is the lowest-numbered hitting slot.
- R10: The record holds inst_addr_i, bus_addr_i, bus_data_i and cycle_cnt_i as sampled in the hitting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Comparison on; loading blocked |
| shift_i | input | 1 | Shift pulse for the slot chain |
| shift_bit_i | input | 1 | Serial configuration bit |
| step_i | input | 1 | Releases a held halt |
| bus_valid_i | input | 1 | Bus cycle completes this clock |
| bus_fetch_i | input | 1 | Cycle is an opcode fetch |
| bus_rd_i | input | 1 | Cycle is a read |
| bus_wr_i | input | 1 | Cycle is a write |
| bus_addr_i | input | 16 | Bus address |
| bus_data_i | input | 8 | Bus data |
| inst_addr_i | input | 16 | Address of the current instruction |
| cycle_cnt_i | input | 24 | Free-running cycle count |
| halt_o | output | 1 | Halt request to the CPU |
| push_o | output | 1 | Record valid for the event FIFO |
| push_iaddr_o | output | 16 | Record instruction address |
| push_baddr_o | output | 16 | Record bus address |
| push_data_o | output | 8 | Record bus data |
| push_mode_o | output | 4 | Compressed mode code |
| push_slot_o | output | 2 | Lowest hitting slot |
| push_cnt_o | output | 24 | Record cycle count |

## Verification
The bench aims at the cases where slot ordering and classification are easy to get wrong. Shifting while comparison is on must not corrupt the slots; a design that shifted anyway would report hits at an address that no loaded slot covers. A slot with a zero mask and zero mode would match every address, so a design that skipped the mode gate would fire on every cycle. Some cycles carry both break and watch hits, or watch hits in two slots. A wrong priority shows up as a watch code where a break code belongs, or as a higher slot number. Cycles that assert fetch together with read, or write together with read, show whether the fetch > write > read order holds. Steps and disables while halted show whether the halt hold logic works.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int MODE_W = 6;
  localparam int TRIG_W = 4;
  // mode bit positions; lower three are break, upper three watch
  localparam int M_BRK_EXEC = 0;
  localparam int M_WAT_EXEC = 3;
  // one-hot access type: [0] fetch, [1] read, [2] write
  typedef logic [2:0] acc_t;
endpackage

// File: rtl/bw_classify.sv
module bw_classify
  import bw_pkg::*;
(
  input  logic valid_i,
  input  logic fetch_i,
  input  logic rd_i,
  input  logic wr_i,
  output acc_t acc_o
);
  always_comb begin
    acc_o = '0;
    if (valid_i) begin
      if (fetch_i)   acc_o[0] = 1'b1;
      else if (wr_i) acc_o[2] = 1'b1;
      else if (rd_i) acc_o[1] = 1'b1;
    end
  end

  always_comb begin
    a_r5_acc_onehot: assert ($onehot0(acc_o));
  end
endmodule

// File: rtl/bw_slot_chain.sv
module bw_slot_chain
  import bw_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 16,
  localparam int CFG_W    = 2*ADDR_W + MODE_W,
  localparam int SLOT_W   = CFG_W + TRIG_W,
  localparam int CHAIN_W  = NUM_SLOTS*SLOT_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lock_i,
  input  logic                       shift_i,
  input  logic                       bit_i,
  output logic [NUM_SLOTS*CFG_W-1:0] cfg_o
);
  logic [CHAIN_W-1:0] chain_q;

  // new bits enter at the top; first bit loaded ends at bit 0 of slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                chain_q <= '0;
    else if (shift_i && !lock_i) chain_q <= {bit_i, chain_q[CHAIN_W-1:1]};
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cfg
    assign cfg_o[s*CFG_W +: CFG_W] = chain_q[s*SLOT_W +: CFG_W];
  end

  a_r2_locked_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(chain_q));
  a_r3_shift_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !lock_i) |=> chain_q[CHAIN_W-1] == $past(bit_i));
endmodule

// File: rtl/bw_slot_match.sv
module bw_slot_match
  import bw_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int CFG_W = 2*ADDR_W + MODE_W
) (
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  acc_t              acc_i,
  output logic [2:0]        brk_o,
  output logic [2:0]        wat_o
);
  logic [ADDR_W-1:0] slot_addr, slot_mask;
  logic [MODE_W-1:0] slot_mode;
  logic              addr_hit;

  assign slot_addr = cfg_i[ADDR_W-1:0];
  assign slot_mask = cfg_i[2*ADDR_W-1:ADDR_W];
  assign slot_mode = cfg_i[CFG_W-1:2*ADDR_W];
  assign addr_hit  = (addr_i & slot_mask) == slot_addr;
  assign brk_o = addr_hit ? (slot_mode[M_BRK_EXEC +: 3] & acc_i) : 3'b000;
  assign wat_o = addr_hit ? (slot_mode[M_WAT_EXEC +: 3] & acc_i) : 3'b000;

  always_comb begin
    a_r5_zero_mode_silent: assert (slot_mode != '0 || (brk_o == '0 && wat_o == '0));
  end
endmodule

// File: rtl/bw_event.sv
module bw_event
  import bw_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 24,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enable_i,
  input  logic                      step_i,
  input  logic [NUM_SLOTS-1:0][2:0] brk_i,
  input  logic [NUM_SLOTS-1:0][2:0] wat_i,
  input  logic [ADDR_W-1:0]         iaddr_i,
  input  logic [ADDR_W-1:0]         baddr_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [CNT_W-1:0]          cnt_i,
  output logic                      halt_o,
  output logic                      push_o,
  output logic [ADDR_W-1:0]         push_iaddr_o,
  output logic [ADDR_W-1:0]         push_baddr_o,
  output logic [DATA_W-1:0]         push_data_o,
  output logic [3:0]                push_mode_o,
  output logic [IDX_W-1:0]          push_slot_o,
  output logic [CNT_W-1:0]          push_cnt_o
);
  logic [2:0]       brk_or, wat_or;
  logic [IDX_W-1:0] first_idx;
  logic             any_hit, halt_q;

  always_comb begin
    brk_or    = '0;
    wat_or    = '0;
    first_idx = '0;
    for (int s = NUM_SLOTS-1; s >= 0; s--) begin
      brk_or = brk_or | brk_i[s];
      wat_or = wat_or | wat_i[s];
      if ((brk_i[s] | wat_i[s]) != '0) first_idx = IDX_W'(s);
    end
  end

  assign any_hit = enable_i && ((brk_or | wat_or) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q       <= 1'b0;
      push_o       <= 1'b0;
      push_iaddr_o <= '0;
      push_baddr_o <= '0;
      push_data_o  <= '0;
      push_mode_o  <= '0;
      push_slot_o  <= '0;
      push_cnt_o   <= '0;
    end else begin
      halt_q <= enable_i && ((brk_or != '0) || (halt_q && !step_i));
      push_o <= any_hit;
      if (any_hit) begin
        push_iaddr_o <= iaddr_i;
        push_baddr_o <= baddr_i;
        push_data_o  <= data_i;
        push_mode_o  <= (brk_or != '0) ? {1'b0, brk_or} : {1'b1, wat_or};
        push_slot_o  <= first_idx;
        push_cnt_o   <= cnt_i;
      end
    end
  end

  assign halt_o = halt_q;

  a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !push_o && !halt_o);
  a_r7_halt_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_o) |-> $past(step_i) || !$past(enable_i));
  a_r7_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !step_i && enable_i) |=> halt_o);
  a_r8_mode_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $countones(push_mode_o[2:0]) == 1);
  a_r8_break_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !push_mode_o[3]) |-> halt_o);
endmodule

// File: rtl/bw_unit.sv
module bw_unit
  import bw_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 24,
  localparam int CFG_W    = 2*ADDR_W + MODE_W,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              shift_i,
  input  logic              shift_bit_i,
  input  logic              step_i,
  input  logic              bus_valid_i,
  input  logic              bus_fetch_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [ADDR_W-1:0] inst_addr_i,
  input  logic [CNT_W-1:0]  cycle_cnt_i,
  output logic              halt_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_iaddr_o,
  output logic [ADDR_W-1:0] push_baddr_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic [3:0]        push_mode_o,
  output logic [IDX_W-1:0]  push_slot_o,
  output logic [CNT_W-1:0]  push_cnt_o
);
  logic [NUM_SLOTS*CFG_W-1:0] cfg;
  acc_t                       acc;
  logic [NUM_SLOTS-1:0][2:0]  brk, wat;

  bw_slot_chain #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chain (
    .clk_i, .rst_ni, .lock_i(enable_i), .shift_i, .bit_i(shift_bit_i), .cfg_o(cfg)
  );

  bw_classify u_cls (
    .valid_i(bus_valid_i), .fetch_i(bus_fetch_i), .rd_i(bus_rd_i), .wr_i(bus_wr_i),
    .acc_o(acc)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    bw_slot_match #(.ADDR_W(ADDR_W)) u_match (
      .cfg_i(cfg[s*CFG_W +: CFG_W]), .addr_i(bus_addr_i), .acc_i(acc),
      .brk_o(brk[s]), .wat_o(wat[s])
    );
  end

  bw_event #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_evt (
    .clk_i, .rst_ni, .enable_i, .step_i, .brk_i(brk), .wat_i(wat),
    .iaddr_i(inst_addr_i), .baddr_i(bus_addr_i), .data_i(bus_data_i), .cnt_i(cycle_cnt_i),
    .halt_o, .push_o, .push_iaddr_o, .push_baddr_o, .push_data_o,
    .push_mode_o, .push_slot_o, .push_cnt_o
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i) $rose(rst_ni) |-> !halt_o && !push_o);
  a_r10_push_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(bus_valid_i) && $past(enable_i));
endmodule

// File: tb/bw_unit_tb.sv
module bw_unit_tb;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, sh = 0, sbit = 0, step = 0, vld = 0, fe = 0, rd = 0, wr = 0;
  logic [15:0] baddr = 0, iaddr = 0;
  logic [7:0]  bdata = 0;
  logic [23:0] cnt = 0;
  logic halt, push;
  logic [15:0] p_ia, p_ba;
  logic [7:0]  p_d;
  logic [3:0]  p_m;
  logic [1:0]  p_s;
  logic [23:0] p_c;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_addr [N];
  logic [15:0] m_mask [N];
  logic [5:0]  m_mode [N];
  logic        e_halt = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 24'd1;

  bw_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .shift_i(sh), .shift_bit_i(sbit),
    .step_i(step), .bus_valid_i(vld), .bus_fetch_i(fe), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(baddr), .bus_data_i(bdata), .inst_addr_i(iaddr), .cycle_cnt_i(cnt),
    .halt_o(halt), .push_o(push), .push_iaddr_o(p_ia), .push_baddr_o(p_ba),
    .push_data_o(p_d), .push_mode_o(p_m), .push_slot_o(p_s), .push_cnt_o(p_c)
  );

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bits(logic [41:0] v);
    for (int b = 0; b < 42; b++) begin
      sh = 1; sbit = v[b];
      @(negedge clk);
    end
    sh = 0;
  endtask

  // R3: slot 0 first; addr, mask, mode, trig, each LSB first
  task automatic load_all();
    en = 0;
    @(negedge clk);
    for (int s = 0; s < N; s++)
      shift_bits({4'hA, m_mode[s], m_mask[s], m_addr[s] & m_mask[s]});
    for (int s = 0; s < N; s++) m_addr[s] = m_addr[s] & m_mask[s];
    e_halt = 0;
  endtask

  // one bus cycle: drive at negedge, check at the following negedge
  task automatic cyc(logic v, logic f, logic r, logic w, logic [15:0] a, logic st, string req);
    logic [2:0] acc, bo, wo;
    logic [1:0] first;
    logic hit;
    logic [7:0]  d  = 8'($urandom);
    logic [15:0] ia = 16'($urandom);
    logic [23:0] c_s;
    vld = v; fe = f; rd = r; wr = w; baddr = a; bdata = d; iaddr = ia; step = st;
    acc = !v ? 3'b000 : f ? 3'b001 : w ? 3'b100 : r ? 3'b010 : 3'b000;
    bo = 0; wo = 0; first = 0; hit = 0;
    for (int s = N-1; s >= 0; s--)
      if ((a & m_mask[s]) == m_addr[s] && ((m_mode[s][2:0] | m_mode[s][5:3]) & acc) != 0) begin
        bo |= m_mode[s][2:0] & acc; wo |= m_mode[s][5:3] & acc;
        first = 2'(s); hit = 1;
      end
    hit = hit && en;
    e_halt = en && ((en && bo != 0) || (e_halt && !st));
    c_s = cnt;
    @(negedge clk);
    chk({req, " push"}, 32'(push), 32'(hit));
    chk("R7 halt", 32'(halt), 32'(e_halt));
    if (hit) begin
      chk("R8 mode", 32'(p_m), 32'((bo != 0) ? {1'b0, bo} : {1'b1, wo}));
      chk("R9 slot", 32'(p_s), 32'(first));
      chk("R10 baddr", 32'(p_ba), 32'(a));
      chk("R10 iaddr", 32'(p_ia), 32'(ia));
      chk("R10 data", 32'(p_d), 32'(d));
      chk("R10 cnt", 32'(p_c), 32'(c_s));
    end
    vld = 0; step = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 halt", 32'(halt), 0);
    chk("R1 push", 32'(push), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 push after release", 32'(push), 0);

    // directed configuration
    m_addr[0] = 16'h1200; m_mask[0] = 16'hFF00; m_mode[0] = 6'b010001;
    m_addr[1] = 16'h1234; m_mask[1] = 16'hFFFF; m_mode[1] = 6'b110000;
    m_addr[2] = 16'h0000; m_mask[2] = 16'h0000; m_mode[2] = 6'b000000;
    m_addr[3] = 16'h12F0; m_mask[3] = 16'hFFF0; m_mode[3] = 6'b001100;
    load_all();
    cyc(1, 0, 1, 0, 16'h1234, 0, "R6 disabled");
    en = 1;
    cyc(1, 0, 1, 0, 16'h0005, 0, "R5 zero-mode slot silent");
    cyc(1, 0, 1, 0, 16'h1234, 0, "R9 two watch slots");
    cyc(1, 0, 0, 1, 16'h1234, 0, "R8 watch write");
    cyc(1, 0, 1, 1, 16'h1234, 0, "R5 write over read");
    cyc(1, 1, 1, 0, 16'h12F3, 0, "R8 break over watch");
    cyc(0, 0, 0, 0, 16'h0000, 0, "R7 hold");
    cyc(1, 0, 1, 0, 16'h5555, 0, "R4 masked miss");
    cyc(0, 0, 0, 0, 16'h0000, 1, "R7 step release");
    cyc(1, 0, 0, 1, 16'h12F5, 0, "R4 masked hit");
    en = 0;
    cyc(0, 0, 0, 0, 16'h0000, 0, "R7 disable release");
    en = 1;
    // R2: shifting ones while enabled must not take effect
    @(negedge clk);
    shift_bits('1);
    shift_bits('1);
    cyc(1, 0, 1, 0, 16'h0005, 0, "R2 load ignored");
    cyc(1, 1, 0, 0, 16'hFFFF, 0, "R2 load ignored");

    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int s = 0; s < N; s++) begin
        m_mask[s] = 16'($urandom) | 16'hF000;
        m_addr[s] = 16'($urandom);
        m_mode[s] = ($urandom % 5 == 0) ? 6'd0 : 6'($urandom);
      end
      load_all();
      en = 1;
      for (int i = 0; i < 400; i++) begin
        int k = $urandom % N;
        logic [15:0] a = ($urandom % 4 == 0) ? 16'($urandom)
                         : ((m_addr[k] & m_mask[k]) | (16'($urandom) & ~m_mask[k]));
        if (i == 200) en = 0;
        if (i == 205) en = 1;
        cyc($urandom % 5 != 0, $urandom % 3 == 0, $urandom % 2 == 0, $urandom % 3 == 0,
            a, $urandom % 8 == 0, "R4 R5 R8 random");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule